// File: doc/BRIEF.md
# Two-Level Latched Interrupt Aggregator

This block gathers single-cycle event pulses from on-chip sources into seven 16-bit status registers, which form the second level. Each event is held until the host reads that register. Every status register has a mask register beside it. The unmasked bits are combined, by source group, into a 16-bit summary register, which forms the first level. The summary register has its own mask. The result drives a single interrupt pin, and a control bit selects whether that pin is active-high or active-low.

The host reaches every register through a synchronous port with separate read and write strobes. Read data appears one cycle after the read strobe. A service routine works in three steps. It reads the summary register to find which groups are pending. It reads the status registers for those groups, and each read clears the register it returns. If a new event arrives while this is under way, the pin asserts again, so the routine runs a second pass.

Top module: `irq_hub`

## Requirements
- R1: After reset, every status register reads 0, every mask register reads 16'hFFFF, the summary mask reads 16'hFFFF, the control register reads 0, and `irq_o` is high because the pin defaults to active-low with no interrupt.
- R2: A pulse on `evt_i[16*r+b]` sets bit b of status register r on the next clock edge. The bit then holds until that register is read. This applies whatever the mask holds.
- R3: A read of status register r (address r, for r from 0 to 6) returns its contents on `host_rdata` one cycle after the strobe, and clears the register at the same edge.
- R4: If an event pulse and a clearing read hit the same register in the same cycle, the new event is kept. The read data excludes it, and the pin asserts again.
- R5: Mask register r sits at address 8+r, and a 1 blocks the matching status bit. Some positions cannot be written and always read 1: bits 15:12 of register 3 and bits 15:13 of register 5.
- R6: The summary register is at address 16, and each of its bits is the OR of the unmasked status bits of one group. The groups are as follows. Register 0 bits 7:0 feed summary bit 0, and bits 15:8 feed bit 1. Register 1 bits 3:0, 7:4, 11:8 and 15:12 feed summary bits 2, 3, 4 and 5. Register 6 bits 7:0, 11:8 and 15:12 feed summary bits 6, 7 and 8. Registers 5, 3, 4 and 2 feed summary bits 9, 10, 11 and 12. Summary bits 15:13 read 0.
- R7: The summary mask at address 17 gates the summary bits, with a 1 blocking. An interrupt is pending when any summary bit is set and unmasked.
- R8: Bit 0 of the control register at address 18 sets the pin polarity. When it is 1, `irq_o` equals pending. When it is 0, `irq_o` equals the inverse of pending.
- R9: Reading the summary register clears nothing. Writes to status or summary addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | 112 | Event pulses, bit 16*r+b targets status register r, bit b |
| host_addr | input | 5 | Register address |
| host_wr | input | 1 | Write strobe |
| host_wdata | input | 16 | Write data |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 16 | Read data, valid one cycle after the strobe |
| irq_o | output | 1 | Interrupt pin with programmable polarity |

## Verification
The assertions assume three things about the inputs. Event pulses are driven from the clock domain. A read strobe and a write strobe never arrive in the same cycle. Addresses outside the map are only ever read, never written. The stimulus drives each host access with a separate task that raises exactly one strobe for one cycle. Events are held low until reset is released. Every event bit is swept individually with all writable masks open, and the collision, masking and polarity cases are then driven one at a time.

// File: rtl/irq_hub_pkg.sv
// Shared constants and the fixed source-group map for the interrupt aggregator.
package irq_hub_pkg;
    localparam int SUB_N      = 7;
    localparam int REG_W      = 16;
    localparam int ADDR_W     = 5;
    localparam int GRP_W      = 4;
    localparam int MASK_BASE  = 8;
    localparam int ADDR_TOP   = 16;
    localparam int ADDR_TMSK  = 17;
    localparam int ADDR_CTRL  = 18;

    // Mask positions that cannot be written and always read as 1.
    function automatic logic [REG_W-1:0] fixed_mask_bits(input int r);
        case (r)
            3:       return 16'hF000;
            5:       return 16'hE000;
            default: return '0;
        endcase
    endfunction

    // Summary bit fed by bit b of status register r.
    function automatic logic [GRP_W-1:0] grp_of(input int r, input int b);
        case (r)
            0:       return (b < 8) ? 4'd0 : 4'd1;
            1:       return (b < 4) ? 4'd2 : (b < 8) ? 4'd3 : (b < 12) ? 4'd4 : 4'd5;
            2:       return 4'd12;
            3:       return 4'd10;
            4:       return 4'd11;
            5:       return 4'd9;
            default: return (b < 8) ? 4'd6 : (b < 12) ? 4'd7 : 4'd8;
        endcase
    endfunction
endpackage

// File: rtl/irq_status_bank.sv
// One second-level register pair: a sticky status register that clears on
// read, plus its mask. Assumes clr is a single-cycle read strobe. A new event
// in the clearing cycle survives. Positions in FIXED are forced to 1 in the mask.
module irq_status_bank #(
    parameter int              REG_W = 16,
    parameter logic [REG_W-1:0] FIXED = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] evt,
    input  logic             clr,
    input  logic             mwr,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] stat,
    output logic [REG_W-1:0] mask,
    output logic [REG_W-1:0] eff
);
    // Latch events; a read clears old bits but keeps same-cycle arrivals.
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= '0;
        else        stat <= (clr ? '0 : stat) | evt;
    end

    // Mask register; fixed positions cannot be written to 0.
    always_ff @(posedge clk) begin
        if (!rst_n)   mask <= '1;
        else if (mwr) mask <= wdata | FIXED;
    end

    // Unmasked status bits.
    always_comb eff = stat & ~mask;
endmodule

// File: rtl/irq_group_summary.sv
// Combines the unmasked second-level bits into the first-level summary word,
// using the group map in the package. Purely combinational.
module irq_group_summary
    import irq_hub_pkg::*;
#(
    parameter int N_REG = 7,
    parameter int W     = 16
) (
    input  logic [N_REG-1:0][W-1:0] eff,
    output logic [W-1:0]            top
);
    // OR every unmasked bit into the summary bit of its group.
    always_comb begin
        top = '0;
        for (int r = 0; r < N_REG; r++) begin
            for (int b = 0; b < W; b++) begin
                top[grp_of(r, b)] = top[grp_of(r, b)] | eff[r][b];
            end
        end
    end
endmodule

// File: rtl/irq_reg_port.sv
// Read side of the host port: selects a register by address and registers it,
// giving one cycle of read latency. Unmapped addresses read 0.
module irq_reg_port
    import irq_hub_pkg::*;
#(
    parameter int N_REG = 7,
    parameter int W     = 16,
    parameter int AW    = 5
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    rd,
    input  logic [AW-1:0]           addr,
    input  logic [N_REG-1:0][W-1:0] stat,
    input  logic [N_REG-1:0][W-1:0] mask,
    input  logic [W-1:0]            top,
    input  logic [W-1:0]            top_mask,
    input  logic                    pol,
    output logic [W-1:0]            rdata
);
    logic [W-1:0] sel;

    // Address decode into a single word.
    always_comb begin
        sel = '0;
        for (int i = 0; i < N_REG; i++) begin
            if (addr == AW'(i))             sel = stat[i];
            if (addr == AW'(MASK_BASE + i)) sel = mask[i];
        end
        if (addr == AW'(ADDR_TOP))  sel = top;
        if (addr == AW'(ADDR_TMSK)) sel = top_mask;
        if (addr == AW'(ADDR_CTRL)) sel = {{(W-1){1'b0}}, pol};
    end

    // Registered read data.
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= sel;
    end
endmodule

// File: rtl/irq_hub.sv
// Two-level interrupt aggregator top. It holds the status banks, the summary
// mask, the polarity control and the pin driver. Assumes a single host that
// never raises host_rd and host_wr in the same cycle.
module irq_hub
    import irq_hub_pkg::*;
#(
    parameter int N_REG = SUB_N,
    parameter int W     = REG_W,
    parameter int AW    = ADDR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_REG*W-1:0] evt_i,
    input  logic [AW-1:0]      host_addr,
    input  logic               host_wr,
    input  logic [W-1:0]       host_wdata,
    input  logic               host_rd,
    output logic [W-1:0]       host_rdata,
    output logic               irq_o
);
    logic [N_REG-1:0][W-1:0] stat_q;
    logic [N_REG-1:0][W-1:0] mask_q;
    logic [N_REG-1:0][W-1:0] eff;
    logic [W-1:0]            top_raw;
    logic [W-1:0]            top_mask_q;
    logic                    pol_q;
    logic                    pending;

    for (genvar g = 0; g < N_REG; g++) begin : g_bank
        logic rd_hit, mwr_hit;
        // Per-register strobe decode.
        always_comb begin
            rd_hit  = host_rd && (host_addr == AW'(g));
            mwr_hit = host_wr && (host_addr == AW'(MASK_BASE + g));
        end
        irq_status_bank #(.REG_W(W), .FIXED(W'(fixed_mask_bits(g)))) u_bank (
            .clk   (clk),
            .rst_n (rst_n),
            .evt   (evt_i[g*W +: W]),
            .clr   (rd_hit),
            .mwr   (mwr_hit),
            .wdata (host_wdata),
            .stat  (stat_q[g]),
            .mask  (mask_q[g]),
            .eff   (eff[g])
        );
    end

    irq_group_summary #(.N_REG(N_REG), .W(W)) u_sum (
        .eff (eff),
        .top (top_raw)
    );

    // Summary mask and polarity control registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_mask_q <= '1;
            pol_q      <= 1'b0;
        end else if (host_wr) begin
            if (host_addr == AW'(ADDR_TMSK)) top_mask_q <= host_wdata;
            if (host_addr == AW'(ADDR_CTRL)) pol_q      <= host_wdata[0];
        end
    end

    irq_reg_port #(.N_REG(N_REG), .W(W), .AW(AW)) u_port (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (host_rd),
        .addr     (host_addr),
        .stat     (stat_q),
        .mask     (mask_q),
        .top      (top_raw),
        .top_mask (top_mask_q),
        .pol      (pol_q),
        .rdata    (host_rdata)
    );

    // Pin driver with selectable active level.
    always_comb begin
        pending = |(top_raw & ~top_mask_q);
        irq_o   = pol_q ? pending : ~pending;
    end
endmodule

// File: rtl/irq_hub_checker.sv
// Temporal checks on the aggregator, attached to every irq_hub by bind.
// Assumes events are clock-synchronous and read and write strobes never overlap.
module irq_hub_checker #(
    parameter int N_REG = 7,
    parameter int W     = 16,
    parameter int AW    = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [N_REG*W-1:0] evt_i,
    input logic               host_rd,
    input logic [AW-1:0]      host_addr,
    input logic [W-1:0]       host_rdata,
    input logic               irq_o,
    input logic [N_REG*W-1:0] stat,
    input logic [W-1:0]       top_raw,
    input logic [W-1:0]       top_mask,
    input logic               pol
);
    logic [AW-1:0] last_addr;
    logic [W-1:0]  sel_stat, sel_evt, stat_at_last;
    logic          rd_sub;

    // Remember the previous address for post-read checks.
    always_ff @(posedge clk) begin
        if (!rst_n) last_addr <= '0;
        else        last_addr <= host_addr;
    end

    // Slices addressed now and in the previous cycle.
    always_comb begin
        rd_sub       = host_rd && (int'(host_addr) < N_REG);
        sel_stat     = '0;
        sel_evt      = '0;
        stat_at_last = '0;
        if (int'(host_addr) < N_REG) begin
            sel_stat = stat[int'(host_addr)*W +: W];
            sel_evt  = evt_i[int'(host_addr)*W +: W];
        end
        if (int'(last_addr) < N_REG) stat_at_last = stat[int'(last_addr)*W +: W];
    end

    p_evt_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i != '0) |=> ((stat & $past(evt_i)) == $past(evt_i)));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !host_rd |=> ((stat & $past(stat)) == $past(stat)));

    p_clear_r3_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sub |=> (stat_at_last == $past(sel_evt)));

    p_rdata_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_sub |=> (host_rdata == $past(sel_stat)));

    p_top_noclear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && !rd_sub && evt_i == '0) |=> (stat == $past(stat)));

    p_idle_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (stat == '0) |-> (top_raw == '0));

    p_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ((top_raw & ~top_mask) == '0) |-> (irq_o == !pol));

    p_level_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ((top_raw & ~top_mask) != '0) |-> (irq_o == pol));
endmodule

bind irq_hub irq_hub_checker #(.N_REG(N_REG), .W(W), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (evt_i),
    .host_rd    (host_rd),
    .host_addr  (host_addr),
    .host_rdata (host_rdata),
    .irq_o      (irq_o),
    .stat       (stat_q),
    .top_raw    (top_raw),
    .top_mask   (top_mask_q),
    .pol        (pol_q)
);

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
    localparam int NR = 7;
    localparam int RW = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NR*RW-1:0] evt_i = '0;
    logic [4:0]     host_addr = '0;
    logic           host_wr = 1'b0;
    logic [15:0]    host_wdata = '0;
    logic           host_rd = 1'b0;
    logic [15:0]    host_rdata;
    logic           irq_o;

    int n_chk = 0;
    int n_bad = 0;

    irq_hub u_irq_hub (
        .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .host_addr(host_addr),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .host_rdata(host_rdata), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    // Group map and fixed mask bits as written in R5 and R6.
    function automatic int exp_group(int r, int b);
        if (r == 0) return b / 8;
        if (r == 1) return 2 + b / 4;
        if (r == 6) return (b < 8) ? 6 : (b < 12 ? 7 : 8);
        if (r == 2) return 12;
        if (r == 3) return 10;
        if (r == 4) return 11;
        return 9;
    endfunction

    function automatic logic [15:0] exp_fixed(int r);
        if (r == 3) return 16'hF000;
        if (r == 5) return 16'hE000;
        return 16'h0000;
    endfunction

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input int a, output logic [15:0] d);
        @(negedge clk);
        host_addr = 5'(a); host_rd = 1'b1;
        @(negedge clk);
        host_rd = 1'b0;
        d = host_rdata;
    endtask

    task automatic wr(input int a, input logic [15:0] d);
        @(negedge clk);
        host_addr = 5'(a); host_wdata = d; host_wr = 1'b1;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic pulse(input int idx);
        @(negedge clk);
        evt_i[idx] = 1'b1;
        @(negedge clk);
        evt_i = '0;
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check("R1 irq_o", {15'd0, irq_o}, 16'd1);
        for (int r = 0; r < NR; r++) begin
            rd(r, d);          check("R1 status", d, 16'h0000);
            rd(8 + r, d);      check("R1 mask", d, 16'hFFFF);
        end
        rd(17, d); check("R1 top mask", d, 16'hFFFF);
        rd(18, d); check("R1 control", d, 16'h0000);

        // R5: write zeros to masks, fixed positions still read 1
        for (int r = 0; r < NR; r++) begin
            wr(8 + r, 16'h0000);
            rd(8 + r, d); check("R5 mask readback", d, exp_fixed(r));
        end
        wr(8 + 1, 16'h5A5A);
        rd(8 + 1, d); check("R5 mask pattern", d, 16'h5A5A);
        wr(8 + 1, 16'h0000);
        wr(17, 16'h0000);
        wr(18, 16'h0001);
        rd(18, d); check("R8 control readback", d, 16'h0001);

        // R2 R3 R6 R8: sweep every event bit, active-high pin
        for (int r = 0; r < NR; r++) begin
            for (int b = 0; b < RW; b++) begin
                logic open;
                open = !exp_fixed(r)[b];
                pulse(r * RW + b);
                check("R8 irq after event", {15'd0, irq_o}, {15'd0, open});
                rd(16, d);
                check("R6 summary", d, open ? 16'(1 << exp_group(r, b)) : 16'h0000);
                rd(r, d);
                check("R2 R3 status read", d, 16'(1 << b));
                check("R3 irq after clear", {15'd0, irq_o}, 16'd0);
                rd(r, d);
                check("R3 cleared", d, 16'h0000);
            end
        end

        // R9: summary read does not clear; status writes ignored
        pulse(5 * RW + 2);
        rd(16, d); check("R9 summary", d, 16'h0200);
        rd(16, d); check("R9 summary kept", d, 16'h0200);
        wr(5, 16'h0000);
        wr(16, 16'h0000);
        rd(5, d); check("R9 status write ignored", d, 16'h0004);

        // R4: event and clearing read in the same cycle
        pulse(0 * RW + 3);
        @(negedge clk);
        host_addr = 5'd0; host_rd = 1'b1; evt_i[0 * RW + 9] = 1'b1;
        @(negedge clk);
        host_rd = 1'b0; evt_i = '0;
        check("R4 read excludes new", host_rdata, 16'h0008);
        check("R4 irq reasserts", {15'd0, irq_o}, 16'd1);
        rd(0, d); check("R4 new event kept", d, 16'h0200);
        check("R4 irq idle", {15'd0, irq_o}, 16'd0);

        // R7: summary mask gates the pin
        pulse(4 * RW + 0);
        wr(17, 16'h0800);
        check("R7 gated", {15'd0, irq_o}, 16'd0);
        rd(16, d); check("R7 summary still set", d, 16'h0800);
        wr(17, 16'h0000);
        check("R7 ungated", {15'd0, irq_o}, 16'd1);

        // R8: active-low polarity
        wr(18, 16'h0000);
        check("R8 active low", {15'd0, irq_o}, 16'd0);
        rd(4, d); check("R8 clear status", d, 16'h0001);
        check("R8 idle high", {15'd0, irq_o}, 16'd1);

        // R5: masked second-level bit does not reach the summary
        wr(8 + 2, 16'h0001);
        pulse(2 * RW + 0);
        rd(16, d); check("R5 masked source", d, 16'h0000);
        check("R5 masked irq", {15'd0, irq_o}, 16'd1);
        rd(2, d); check("R5 status latched", d, 16'h0001);

        finish_run();
    end
endmodule